// File: doc/BRIEF.md
# Fail-Secure Configuration Word Loader

This block fetches a small table of persistent security settings from a synchronous, read-only storage port. It does this once after reset and again each time software pulses a reload request. There are four entries. Entry 0 is the protection level. Entries 1 to 3 are boolean lock flags, and for each flag TRUE is the restrictive setting. Every entry sits at two storage words: the value word at address 2i and a bitwise-complement copy at address 2i+1. An entry is accepted only when its value is one of the exact 8-bit patterns defined for it and its copy is the exact complement of the value. An entry that fails either test is replaced by its most restrictive setting and is recorded in an error bitmap.

While a load is in progress, the published outputs stay at the most restrictive configuration. They switch to the decoded values in the same cycle that the busy flag drops. A write-lock output is held high whenever the published protection level is above level 0, and also during any load. Logic that programs the storage uses this output to refuse updates to the configuration words.

The storage read port is a fixed-latency pull interface with no back-pressure. The loader raises `rd_en` for one cycle with an address. The word arrives on `rd_data` two cycles later and is sampled in that cycle. The storage must accept a request in any cycle. The loader never has more than one request outstanding.

Top module: `cfg_word_loader`

## Requirements
- R1: After reset is released, a full load starts without any request, and `busy` stays high until all four entries have been checked.
- R2: When `reload_req` is high for one cycle while `busy` is low, a new load starts, and `busy` is high in the following cycle.
- R3: A flag entry decodes to 1 when its value word is 0xB4 and to 0 when it is 0xC3. Any other value word is an error, and the flag is published as 1. Entry k (k = 1..3) drives bit k-1 of `lock_flags`.
- R4: When the value word XOR the copy word is not 0xFF, the entry is an error and takes its restrictive setting: level 2 or flag 1.
- R5: The level entry (entry 0) decodes 0x5A to level 0, 0x96 to level 1 and 0x69 to level 2. Any other value word is an error and decodes to level 2.
- R6: A factory image gives level 0, all flags 0, no errors and `write_lock` low. The factory image is 0x5A for the level, 0xC3 for every flag, and each copy equal to the complement of its value.
- R7: While `busy` is high, including during reset, `prot_level` is 2, every `lock_flags` bit is 1, and `write_lock` is 1.
- R8: `write_lock` is high whenever the published `prot_level` is not 0. It is low only when the level is 0 and no load is running.
- R9: Bit i of `err_map` is set when entry i failed in the current or latest load, and `load_err` is the OR of those bits. Both clear when a load starts.
- R10: Each load issues exactly eight reads, in address order 0 to 7. Each read's data is taken two cycles after its `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reload_req | input | 1 | One-cycle request for a new load; ignored while busy |
| rd_en | output | 1 | Storage read strobe |
| rd_addr | output | 3 | Storage word address |
| rd_data | input | 8 | Storage word, valid two cycles after `rd_en` |
| busy | output | 1 | Load in progress |
| prot_level | output | 2 | Published protection level, 0 to 2 |
| lock_flags | output | 3 | Published flag entries 1 to 3 |
| write_lock | output | 1 | Configuration update lock |
| err_map | output | 4 | Per-entry error bits of the latest load |
| load_err | output | 1 | Any entry failed in the latest load |

## Verification
The level entry is driven with each of its three valid patterns and with arbitrary bytes. This tells a correct decode apart from the fallback to level 2, and shows whether that fallback raises an error. The flag entries are given both magic values, near-miss values such as 0xB5, and correct values paired with a single-bit-flipped copy. These cases separate the magic-pattern test from the complement test. A factory image is loaded after a run of corrupted images, which shows that the error bits clear. Random images mix all of these cases across the four entries.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam logic [7:0] FLAG_ON_PAT  = 8'hB4;
  localparam logic [7:0] FLAG_OFF_PAT = 8'hC3;
  localparam logic [7:0] LVL0_PAT     = 8'h5A;
  localparam logic [7:0] LVL1_PAT     = 8'h96;
  localparam logic [7:0] LVL2_PAT     = 8'h69;
  localparam logic [7:0] COMPL_MASK   = 8'hFF;
  localparam logic [1:0] LVL_SECURE   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_VAL, ST_RD_CPY, ST_CHECK, ST_NEXT, ST_DONE
  } ld_state_e;

  typedef enum logic {KIND_LEVEL, KIND_FLAG} entry_kind_e;
endpackage

// File: rtl/cfgld_pair_check.sv
module cfgld_pair_check
  import cfgld_pkg::*;
#(
  parameter entry_kind_e KIND = KIND_FLAG,
  parameter int          OW   = (KIND == KIND_LEVEL) ? 2 : 1
) (
  input  logic [7:0]    val_i,
  input  logic [7:0]    cpy_i,
  output logic [OW-1:0] dec_o,
  output logic          err_o
);
  logic pair_ok;
  assign pair_ok = ((val_i ^ cpy_i) == COMPL_MASK);

  generate
    if (KIND == KIND_LEVEL) begin : g_level
      always_comb begin
        dec_o = OW'(LVL_SECURE);
        err_o = 1'b1;
        if (pair_ok) begin
          unique case (val_i)
            LVL0_PAT: begin dec_o = OW'(0); err_o = 1'b0; end
            LVL1_PAT: begin dec_o = OW'(1); err_o = 1'b0; end
            LVL2_PAT: begin dec_o = OW'(2); err_o = 1'b0; end
            default:  begin dec_o = OW'(LVL_SECURE); err_o = 1'b1; end
          endcase
        end
      end
    end else begin : g_flag
      always_comb begin
        dec_o = '1;
        err_o = 1'b1;
        if (pair_ok) begin
          unique case (val_i)
            FLAG_ON_PAT:  begin dec_o = '1; err_o = 1'b0; end
            FLAG_OFF_PAT: begin dec_o = '0; err_o = 1'b0; end
            default:      begin dec_o = '1; err_o = 1'b1; end
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int NE  = 4,
  parameter int LAT = 2,
  parameter int IW  = (NE > 1) ? $clog2(NE) : 1,
  parameter int AW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reload_req,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic [7:0]    val_o,
  output logic [7:0]    cpy_o,
  output logic [IW-1:0] idx_o,
  output logic          load_start,
  output logic          chk_en,
  output logic          commit,
  output logic          busy
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LAT);
  localparam logic [IW-1:0] IDX_LAST = IW'(NE - 1);

  ld_state_e state_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [7:0] val_q, cpy_q;
  logic reading;

  assign reading    = (state_q == ST_RD_VAL) || (state_q == ST_RD_CPY);
  assign rd_en      = reading && (cnt_q == '0);
  assign rd_addr    = {idx_q, (state_q == ST_RD_CPY)};
  assign load_start = (state_q == ST_IDLE) || ((state_q == ST_DONE) && reload_req);
  assign chk_en     = (state_q == ST_CHECK);
  assign commit     = (state_q == ST_NEXT) && (idx_q == IDX_LAST);
  assign busy       = (state_q != ST_DONE);
  assign val_o      = val_q;
  assign cpy_o      = cpy_q;
  assign idx_o      = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      val_q   <= '0;
      cpy_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          idx_q   <= '0;
          cnt_q   <= '0;
          state_q <= ST_RD_VAL;
        end
        ST_RD_VAL: begin
          if (cnt_q == CNT_LAST) begin
            val_q   <= rd_data;
            cnt_q   <= '0;
            state_q <= ST_RD_CPY;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_CPY: begin
          if (cnt_q == CNT_LAST) begin
            cpy_q   <= rd_data;
            cnt_q   <= '0;
            state_q <= ST_CHECK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CHECK: state_q <= ST_NEXT;
        ST_NEXT: begin
          if (idx_q == IDX_LAST) begin
            state_q <= ST_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= ST_RD_VAL;
          end
        end
        ST_DONE: begin
          if (reload_req) begin
            idx_q   <= '0;
            cnt_q   <= '0;
            state_q <= ST_RD_VAL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_regs.sv
module cfgld_regs
  import cfgld_pkg::*;
#(
  parameter int NE = 4,
  parameter int IW = (NE > 1) ? $clog2(NE) : 1,
  parameter int NF = NE - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_start,
  input  logic          chk_en,
  input  logic          commit,
  input  logic [IW-1:0] idx_i,
  input  logic [1:0]    lvl_dec,
  input  logic          lvl_err,
  input  logic          flg_dec,
  input  logic          flg_err,
  output logic [1:0]    prot_level,
  output logic [NF-1:0] lock_flags,
  output logic          write_lock,
  output logic [NE-1:0] err_map,
  output logic          load_err
);
  logic [1:0]    lvl_sh;
  logic [NF-1:0] flg_sh;
  logic          cur_err;

  assign cur_err = (idx_i == '0) ? lvl_err : flg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lvl_sh <= LVL_SECURE;
    else if (load_start)                 lvl_sh <= LVL_SECURE;
    else if (chk_en && idx_i == '0)      lvl_sh <= lvl_dec;
  end

  generate
    for (genvar g = 0; g < NF; g++) begin : g_flag_sh
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 flg_sh[g] <= 1'b1;
        else if (load_start)                        flg_sh[g] <= 1'b1;
        else if (chk_en && idx_i == IW'(g + 1))     flg_sh[g] <= flg_dec;
      end
    end
    for (genvar e = 0; e < NE; e++) begin : g_err
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 err_map[e] <= 1'b0;
        else if (load_start)                        err_map[e] <= 1'b0;
        else if (chk_en && idx_i == IW'(e))         err_map[e] <= cur_err;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               load_err <= 1'b0;
    else if (load_start)      load_err <= 1'b0;
    else if (chk_en && cur_err) load_err <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_level <= LVL_SECURE;
      lock_flags <= '1;
      write_lock <= 1'b1;
    end else if (load_start) begin
      prot_level <= LVL_SECURE;
      lock_flags <= '1;
      write_lock <= 1'b1;
    end else if (commit) begin
      prot_level <= lvl_sh;
      lock_flags <= flg_sh;
      write_lock <= (lvl_sh != 2'd0);
    end
  end
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cfgld_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int RD_LATENCY  = 2,
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int ADDR_W = IDX_W + 1,
  localparam int NFLAG  = NUM_ENTRIES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_req,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              busy,
  output logic [1:0]        prot_level,
  output logic [NFLAG-1:0]  lock_flags,
  output logic              write_lock,
  output logic [NUM_ENTRIES-1:0] err_map,
  output logic              load_err
);
  logic [7:0]       val_w, cpy_w;
  logic [IDX_W-1:0] idx_w;
  logic             start_w, chk_w, commit_w;
  logic [1:0]       lvl_dec_w;
  logic [0:0]       flg_dec_w;
  logic             lvl_err_w, flg_err_w;

  cfgld_seq #(.NE(NUM_ENTRIES), .LAT(RD_LATENCY), .IW(IDX_W), .AW(ADDR_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .reload_req(reload_req),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .val_o(val_w), .cpy_o(cpy_w), .idx_o(idx_w),
    .load_start(start_w), .chk_en(chk_w), .commit(commit_w), .busy(busy)
  );

  cfgld_pair_check #(.KIND(KIND_LEVEL), .OW(2)) lvl_chk_i (
    .val_i(val_w), .cpy_i(cpy_w), .dec_o(lvl_dec_w), .err_o(lvl_err_w)
  );

  cfgld_pair_check #(.KIND(KIND_FLAG), .OW(1)) flg_chk_i (
    .val_i(val_w), .cpy_i(cpy_w), .dec_o(flg_dec_w), .err_o(flg_err_w)
  );

  cfgld_regs #(.NE(NUM_ENTRIES), .IW(IDX_W), .NF(NFLAG)) regs_i (
    .clk(clk), .rst_n(rst_n), .load_start(start_w), .chk_en(chk_w),
    .commit(commit_w), .idx_i(idx_w),
    .lvl_dec(lvl_dec_w), .lvl_err(lvl_err_w),
    .flg_dec(flg_dec_w[0]), .flg_err(flg_err_w),
    .prot_level(prot_level), .lock_flags(lock_flags), .write_lock(write_lock),
    .err_map(err_map), .load_err(load_err)
  );
endmodule

// File: rtl/cfgld_sva.sv
module cfgld_sva #(
  parameter int NE = 4,
  parameter int AW = ((NE > 1) ? $clog2(NE) : 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [1:0]    prot_level,
  input logic [NE-2:0] lock_flags,
  input logic          write_lock,
  input logic [NE-1:0] err_map,
  input logic          load_err,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr
);
  // R7
  secure_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (prot_level == 2'd2 && (&lock_flags) && write_lock));

  // R8
  lock_on_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_level != 2'd0) |-> write_lock);

  // R8
  open_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && prot_level == 2'd0) |-> !write_lock);

  // R9
  err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_map) |-> load_err);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (err_map == '0 && !load_err));

  // R10
  read_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (busy && int'(rd_addr) < 2 * NE));

  // R1
  stable_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> ($stable(prot_level) && $stable(lock_flags)));
endmodule

bind cfg_word_loader cfgld_sva #(.NE(NUM_ENTRIES), .AW(ADDR_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .prot_level(prot_level),
  .lock_flags(lock_flags), .write_lock(write_lock), .err_map(err_map),
  .load_err(load_err), .rd_en(rd_en), .rd_addr(rd_addr)
);

// File: tb/cfg_word_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_word_loader_tb_top;
  localparam int NE = 4;
  localparam int NW = 2 * NE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload_req = 1'b0;
  logic rd_en;
  logic [2:0] rd_addr;
  logic [7:0] rd_data = '0;
  logic busy;
  logic [1:0] prot_level;
  logic [2:0] lock_flags;
  logic write_lock;
  logic [3:0] err_map;
  logic load_err;

  int compared = 0;
  int mismatched = 0;

  logic [7:0] mem [NW];
  logic [7:0] stage1 = '0;
  int rd_cnt = 0;
  logic [2:0] addr_log [16];

  always #2.5 clk = ~clk;

  cfg_word_loader dut_i (
    .clk(clk), .rst_n(rst_n), .reload_req(reload_req),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .prot_level(prot_level), .lock_flags(lock_flags),
    .write_lock(write_lock), .err_map(err_map), .load_err(load_err)
  );

  // storage model: two-cycle read latency (R10)
  always @(posedge clk) begin
    if (rd_en) begin
      stage1 <= mem[rd_addr];
      addr_log[rd_cnt % 16] <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
    rd_data <= stage1;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input int e, input logic [7:0] v, input logic [7:0] c);
    mem[2*e] = v;
    mem[2*e+1] = c;
  endtask

  task automatic factory();
    put(0, 8'h5A, 8'hA5);
    for (int e = 1; e < NE; e++) put(e, 8'hC3, 8'h3C);
  endtask

  task automatic expect_cfg(output int lvl, output int flags, output int errs);
    lvl = 2; flags = 0; errs = 0;
    for (int e = 0; e < NE; e++) begin
      logic [7:0] v, c;
      bit ok;
      v = mem[2*e]; c = mem[2*e+1];
      ok = ((v ^ c) == 8'hFF);
      if (e == 0) begin
        if (ok && v == 8'h5A) lvl = 0;
        else if (ok && v == 8'h96) lvl = 1;
        else if (ok && v == 8'h69) lvl = 2;
        else begin lvl = 2; errs |= 1; end
      end else begin
        if (ok && v == 8'hB4) flags |= (1 << (e-1));
        else if (ok && v == 8'hC3) flags |= 0;
        else begin flags |= (1 << (e-1)); errs |= (1 << e); end
      end
    end
  endtask

  task automatic finish_load(input int base, input string tag);
    int n = 0;
    int lvl, flags, errs;
    while (busy && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) begin
      mismatched++; compared++;
      $display("FAIL R1 %s: load never ended, actual busy 1 expected 0", tag);
    end
    expect_cfg(lvl, flags, errs);
    chk({"R3/R5 level ", tag}, int'(prot_level), lvl);
    chk({"R3/R4 flags ", tag}, int'(lock_flags), flags);
    chk({"R9 err_map ", tag}, int'(err_map), errs);
    chk({"R9 load_err ", tag}, int'(load_err), int'(errs != 0));
    chk({"R8 write_lock ", tag}, int'(write_lock), int'(lvl != 0));
    chk({"R10 read count ", tag}, rd_cnt - base, NW);
    for (int k = 0; k < NW; k++)
      chk({"R10 read order ", tag}, int'(addr_log[(base + k) % 16]), k);
  endtask

  task automatic reload(input string tag);
    int base;
    @(negedge clk);
    base = rd_cnt;
    reload_req = 1'b1;
    @(negedge clk);
    reload_req = 1'b0;
    chk({"R2 busy after request ", tag}, int'(busy), 1);
    chk({"R7 level in load ", tag}, int'(prot_level), 2);
    chk({"R7 flags in load ", tag}, int'(lock_flags), 7);
    chk({"R7 lock in load ", tag}, int'(write_lock), 1);
    finish_load(base, tag);
  endtask

  function automatic logic [7:0] level_pat(input int k);
    case (k % 3)
      0: return 8'h5A;
      1: return 8'h96;
      default: return 8'h69;
    endcase
  endfunction

  task automatic rand_entry(input int e);
    logic [7:0] v;
    int r = int'($urandom % 5);
    if (e == 0) v = level_pat(int'($urandom % 3));
    else v = ($urandom % 2) ? 8'hB4 : 8'hC3;
    case (r)
      0, 1: put(e, v, ~v);
      2: begin v = 8'($urandom); put(e, v, ~v); end
      3: put(e, v, ~v ^ (8'h1 << ($urandom % 8)));
      default: put(e, 8'($urandom), 8'($urandom));
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    factory();
    repeat (3) @(negedge clk);
    // R7: reset state is the restrictive configuration
    chk("R7 reset busy", int'(busy), 1);
    chk("R7 reset level", int'(prot_level), 2);
    chk("R7 reset flags", int'(lock_flags), 7);
    chk("R7 reset lock", int'(write_lock), 1);
    chk("R9 reset err_map", int'(err_map), 0);
    rst_n = 1'b1;
    // R1, R6: automatic load of factory image
    @(negedge clk);
    chk("R1 busy after reset", int'(busy), 1);
    finish_load(0, "factory after reset");
    chk("R6 open level", int'(prot_level), 0);
    chk("R6 open lock", int'(write_lock), 0);

    // R3, R5, R8: all flags TRUE, level 1
    put(0, 8'h96, 8'h69);
    for (int e = 1; e < NE; e++) put(e, 8'hB4, 8'h4B);
    reload("level1 all on");
    // R5: level 2 valid pattern
    put(0, 8'h69, 8'h96);
    reload("level2 valid");
    // R5: unrecognised level patterns
    put(0, 8'h00, 8'hFF);
    reload("level garbage 00");
    put(0, 8'h5B, 8'hA4);
    reload("level near miss");
    // R3: near miss on a flag
    factory();
    put(2, 8'hB5, 8'h4A);
    reload("flag near miss");
    // R4: bad copy on a FALSE flag and on the level
    factory();
    put(3, 8'hC3, 8'h3D);
    put(0, 8'h5A, 8'hA4);
    reload("bad copies");
    // R9: errors cleared by a clean load
    factory();
    reload("factory again");
    chk("R9 cleared after clean load", int'(err_map), 0);

    for (int i = 0; i < 60; i++) begin
      for (int e = 0; e < NE; e++) rand_entry(e);
      reload("random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule